// File: doc/BRIEF.md
# Vertical Microcode Sequencer

This block is the control unit of a small accumulator machine with four instruction classes: load, store, add and conditional branch. Its control store holds 10-bit microwords in two formats. A transfer word carries a 4-bit transfer code, and a decoder expands that code into datapath enables. A jump word selects one condition input, compares it with a stored bit, and moves the micro-program counter to a target address when the two agree.

Sequencing is driven by the micro-program counter, not by next-state fields. Each transfer word, and each jump whose condition does not match, moves the counter to the following address. Memory handshakes are built from jump words that test the busy input. Instruction decode is a short chain of jumps on the two opcode bits. The datapath samples `ctrl_o` every cycle, and it drives the condition inputs from its instruction register, its accumulator sign and its memory busy line.

Top module: `useq_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces `upc_o` to 0 at once. While in reset, `ctrl_o` shows the enables of word 0 (fetch), which are 9'h003.
- R2: Bit 9 of a microword sets its format, with 0 for a transfer and 1 for a jump. In a jump word, bits [8:7] select the condition (00 `wait_i`, 01 `ir15_i`, 10 `ir14_i`, 11 `ac15_i`), bit 6 is the compare value, and bits [4:0] are the target. In a transfer word, bits [3:0] are the transfer code.
- R3: A transfer word, or a jump whose selected input differs from its compare value, advances `upc_o` by one on the next clock. A jump whose input matches loads the target instead.
- R4: While a jump word is current, all `ctrl_o` bits are 0.
- R5: The `ctrl_o` bits are 0 mar_ld, 1 pc_inc, 2 pc_ld, 3 ir_ld, 4 ac_ld, 5 mbr_ld, 6 mem_req, 7 mem_we and 8 alu_add. The transfer codes give these values: 1 fetch 9'h003, 2 read 9'h040, 3 read-capture 9'h060, 4 ir-load 9'h008, 5 ir-to-mar 9'h001, 6 mbr-to-ac 9'h010, 7 ac-to-mbr 9'h020, 8 write 9'h0C0, 9 add 9'h110, 10 ir-to-pc 9'h004. All other codes give 0.
- R6: Fetch runs through words 0 to 5. Word 2 returns to word 1 while `wait_i`=1.
- R7: The opcode is {IR[15],IR[14]}, with 00 load, 01 store, 10 add and 11 branch. Word 6 jumps to 18 when IR[15]=1. Word 7 jumps to 14 when IR[14]=1, and otherwise falls into load at 8. Word 18 jumps to 25 when IR[14]=1, and otherwise falls into add at 19.
- R8: Memory access words repeat while `wait_i`=1: load read at 8 with check at 9, store write at 15 with check at 16, add read at 19 with check at 20.
- R9: Each routine returns to word 0. Load runs 10, 11 and then the pair 12 (wait=0) and 13 (wait=1). Add runs 21, 22 and then the pair 23 and 24. Store ends at 17 (wait=0). Branch word 25 returns when AC[15]=0; otherwise it runs 26 (ir-to-pc) and then the pair 27 and 28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_i | input | 1 | Memory busy |
| ir15_i | input | 1 | Instruction register bit 15 |
| ir14_i | input | 1 | Instruction register bit 14 |
| ac15_i | input | 1 | Accumulator sign bit |
| upc_o | output | 5 | Micro-program counter |
| ctrl_o | output | 9 | Decoded datapath enables |

## Verification
The sweep covers all four opcodes, both accumulator signs, zero to three busy cycles on every memory access, and both polarities at the paired return jumps. Each combination gives an exact micro-PC trace and an exact enable vector per cycle. The opcode patterns tell the decode chain's targets apart. The busy counts tell loop-back from fall-through in each wait loop. The sign patterns separate a taken branch from an untaken one. The return-pair polarity shows that both words of each pair jump. A reset applied in the middle of fetch shows that the counter clears asynchronously.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int unsigned UW_W   = 10;
  parameter int unsigned UPC_W  = 5;
  parameter int unsigned CODE_W = 4;
  parameter int unsigned CTRL_W = 9;

  localparam int unsigned F_FMT = UW_W - 1;
  localparam int unsigned F_SEL = UW_W - 3;
  localparam int unsigned F_VAL = UW_W - 4;

  typedef logic [UW_W-1:0]  uword_t;
  typedef logic [UPC_W-1:0] upc_t;

  typedef enum logic [1:0] {CS_WAIT, CS_IR15, CS_IR14, CS_AC15} cond_sel_e;

  typedef enum logic [CODE_W-1:0] {
    XF_NOP, XF_FETCH, XF_READ, XF_CAPT, XF_IRLD, XF_IR2MAR,
    XF_MBR2AC, XF_AC2MBR, XF_WRITE, XF_ADD, XF_IR2PC
  } xfer_e;

  localparam int unsigned CB_MAR_LD  = 0;
  localparam int unsigned CB_PC_INC  = 1;
  localparam int unsigned CB_PC_LD   = 2;
  localparam int unsigned CB_IR_LD   = 3;
  localparam int unsigned CB_AC_LD   = 4;
  localparam int unsigned CB_MBR_LD  = 5;
  localparam int unsigned CB_MEM_REQ = 6;
  localparam int unsigned CB_MEM_WE  = 7;
  localparam int unsigned CB_ALU_ADD = 8;

  // routine entry points
  localparam upc_t A_RES = 5'd0;
  localparam upc_t A_ST0 = 5'd14;
  localparam upc_t A_OD1 = 5'd18;
  localparam upc_t A_BR0 = 5'd25;

  function automatic uword_t rt(input xfer_e c);
    return {1'b0, {(UW_W-1-CODE_W){1'b0}}, c};
  endfunction

  function automatic uword_t bj(input cond_sel_e s, input logic v, input upc_t t);
    return {1'b1, s, v, {(UW_W-4-UPC_W){1'b0}}, t};
  endfunction

  function automatic uword_t uprog(input upc_t a);
    case (a)
      5'd0:  return rt(XF_FETCH);
      5'd1:  return rt(XF_READ);
      5'd2:  return bj(CS_WAIT, 1'b1, 5'd1);
      5'd3:  return rt(XF_CAPT);
      5'd4:  return rt(XF_IRLD);
      5'd5:  return rt(XF_IR2MAR);
      5'd6:  return bj(CS_IR15, 1'b1, A_OD1);
      5'd7:  return bj(CS_IR14, 1'b1, A_ST0);
      5'd8:  return rt(XF_READ);
      5'd9:  return bj(CS_WAIT, 1'b1, 5'd8);
      5'd10: return rt(XF_CAPT);
      5'd11: return rt(XF_MBR2AC);
      5'd12: return bj(CS_WAIT, 1'b0, A_RES);
      5'd13: return bj(CS_WAIT, 1'b1, A_RES);
      5'd14: return rt(XF_AC2MBR);
      5'd15: return rt(XF_WRITE);
      5'd16: return bj(CS_WAIT, 1'b1, 5'd15);
      5'd17: return bj(CS_WAIT, 1'b0, A_RES);
      5'd18: return bj(CS_IR14, 1'b1, A_BR0);
      5'd19: return rt(XF_READ);
      5'd20: return bj(CS_WAIT, 1'b1, 5'd19);
      5'd21: return rt(XF_CAPT);
      5'd22: return rt(XF_ADD);
      5'd23: return bj(CS_WAIT, 1'b0, A_RES);
      5'd24: return bj(CS_WAIT, 1'b1, A_RES);
      5'd25: return bj(CS_AC15, 1'b0, A_RES);
      5'd26: return rt(XF_IR2PC);
      5'd27: return bj(CS_WAIT, 1'b0, A_RES);
      5'd28: return bj(CS_WAIT, 1'b1, A_RES);
      5'd30: return bj(CS_WAIT, 1'b1, A_RES);
      default: return bj(CS_WAIT, 1'b0, A_RES);
    endcase
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  upc_t   addr_i,
  output uword_t word_o
);
  always_comb word_o = uprog(addr_i);
endmodule

// File: rtl/useq_cond.sv
module useq_cond
  import useq_pkg::*;
(
  input  uword_t word_i,
  input  logic   wait_i,
  input  logic   ir15_i,
  input  logic   ir14_i,
  input  logic   ac15_i,
  output logic   take_o
);
  logic sel_val;

  always_comb begin
    case (cond_sel_e'(word_i[F_SEL +: 2]))
      CS_WAIT: sel_val = wait_i;
      CS_IR15: sel_val = ir15_i;
      CS_IR14: sel_val = ir14_i;
      default: sel_val = ac15_i;
    endcase
    take_o = word_i[F_FMT] && (sel_val == word_i[F_VAL]);
  end
endmodule

// File: rtl/useq_xdec.sv
module useq_xdec
  import useq_pkg::*;
(
  input  uword_t            word_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    if (!word_i[F_FMT]) begin
      case (word_i[CODE_W-1:0])
        XF_FETCH:  begin ctrl_o[CB_MAR_LD] = 1'b1; ctrl_o[CB_PC_INC] = 1'b1; end
        XF_READ:   ctrl_o[CB_MEM_REQ] = 1'b1;
        XF_CAPT:   begin ctrl_o[CB_MEM_REQ] = 1'b1; ctrl_o[CB_MBR_LD] = 1'b1; end
        XF_IRLD:   ctrl_o[CB_IR_LD] = 1'b1;
        XF_IR2MAR: ctrl_o[CB_MAR_LD] = 1'b1;
        XF_MBR2AC: ctrl_o[CB_AC_LD] = 1'b1;
        XF_AC2MBR: ctrl_o[CB_MBR_LD] = 1'b1;
        XF_WRITE:  begin ctrl_o[CB_MEM_REQ] = 1'b1; ctrl_o[CB_MEM_WE] = 1'b1; end
        XF_ADD:    begin ctrl_o[CB_AC_LD] = 1'b1; ctrl_o[CB_ALU_ADD] = 1'b1; end
        XF_IR2PC:  ctrl_o[CB_PC_LD] = 1'b1;
        default:   ctrl_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_i,
  input  logic              ir15_i,
  input  logic              ir14_i,
  input  logic              ac15_i,
  output logic [UPC_W-1:0]  upc_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  upc_t   upc_q, upc_d;
  uword_t uword;
  logic   take;

  useq_rom u_rom (.addr_i(upc_q), .word_o(uword));

  useq_cond u_cond (
    .word_i(uword), .wait_i(wait_i), .ir15_i(ir15_i),
    .ir14_i(ir14_i), .ac15_i(ac15_i), .take_o(take)
  );

  useq_xdec u_xdec (.word_i(uword), .ctrl_o(ctrl_o));

  always_comb upc_d = take ? uword[UPC_W-1:0] : upc_q + UPC_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  assign upc_o = upc_q;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk
  import useq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wait_i,
  input logic              ir15_i,
  input logic              ir14_i,
  input logic              ac15_i,
  input logic [UPC_W-1:0]  upc_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [UW_W-1:0]   word_i
);
  logic sel_val, is_jump, hit;

  always_comb begin
    case (word_i[F_SEL +: 2])
      2'b00:   sel_val = wait_i;
      2'b01:   sel_val = ir15_i;
      2'b10:   sel_val = ir14_i;
      default: sel_val = ac15_i;
    endcase
    is_jump = word_i[F_FMT];
    hit     = is_jump && (sel_val == word_i[F_VAL]);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_clear_r1: assert (upc_o == '0);
  end

  p_jump_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_jump |-> ctrl_o == '0);

  p_jump_taken_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> upc_o == $past(word_i[UPC_W-1:0]));

  p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> upc_o == UPC_W'($past(upc_o) + 1));

  p_write_has_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[CB_MEM_WE] |-> ctrl_o[CB_MEM_REQ]);

  p_pc_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o[CB_PC_INC], ctrl_o[CB_PC_LD]}));
endmodule

bind useq_ctrl useq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wait_i(wait_i), .ir15_i(ir15_i),
  .ir14_i(ir14_i), .ac15_i(ac15_i), .upc_o(upc_o), .ctrl_o(ctrl_o),
  .word_i(uword)
);

// File: tb/useq_ctrl_test.sv
`timescale 1ns/1ps
module useq_ctrl_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wait_i = 1'b0, ir15_i = 1'b0, ir14_i = 1'b0, ac15_i = 1'b0;
  logic [4:0] upc_o;
  logic [8:0] ctrl_o;
  int n_chk = 0, n_bad = 0;

  localparam logic [8:0] C_FETCH = 9'h003, C_READ = 9'h040, C_CAPT = 9'h060,
    C_IRLD = 9'h008, C_IR2MAR = 9'h001, C_MBR2AC = 9'h010, C_AC2MBR = 9'h020,
    C_WRITE = 9'h0C0, C_ADD = 9'h110, C_IR2PC = 9'h004, C_NONE = 9'h000;

  useq_ctrl uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic check(input logic [4:0] eu, input logic [8:0] ec, input string tag);
    n_chk++;
    if (upc_o !== eu || ctrl_o !== ec) begin
      n_bad++;
      $display("FAIL %s upc=%0d ctrl=%h expected upc=%0d ctrl=%h", tag, upc_o, ctrl_o, eu, ec);
    end
  endtask

  // called at a falling edge; one rising edge passes inside
  task automatic step(input logic [4:0] eu, input logic [8:0] ec, input logic w, input string tag);
    wait_i = w;
    #1 check(eu, ec, tag);
    @(negedge clk_i);
  endtask

  task automatic mem_loop(input logic [4:0] a, input logic [8:0] c, input int k, input string tag);
    for (int i = 0; i < k; i++) begin
      step(a, c, 1'b1, tag);
      step(a + 5'd1, C_NONE, 1'b1, "R3");
    end
    step(a, c, 1'b0, tag);
    step(a + 5'd1, C_NONE, 1'b0, "R3");
  endtask

  task automatic ret_pair(input logic [4:0] a, input logic w);
    step(a, C_NONE, w, "R4");
    if (w) step(a + 5'd1, C_NONE, w, "R9");
  endtask

  task automatic run_instr(input logic [1:0] op, input logic ac, input int k, input logic tw);
    ir15_i = op[1]; ir14_i = op[0]; ac15_i = ac;
    step(5'd0, C_FETCH, 1'b0, "R6");
    mem_loop(5'd1, C_READ, k, "R6");
    step(5'd3, C_CAPT, 1'b0, "R5");
    step(5'd4, C_IRLD, 1'b0, "R5");
    step(5'd5, C_IR2MAR, 1'b0, "R6");
    step(5'd6, C_NONE, 1'b0, "R2");
    if (op[1]) begin
      step(5'd18, C_NONE, 1'b0, "R7");
      if (op[0]) begin
        step(5'd25, C_NONE, 1'b0, "R9");
        if (ac) begin
          step(5'd26, C_IR2PC, 1'b0, "R9");
          ret_pair(5'd27, tw);
        end
      end else begin
        mem_loop(5'd19, C_READ, k, "R8");
        step(5'd21, C_CAPT, 1'b0, "R5");
        step(5'd22, C_ADD, 1'b0, "R9");
        ret_pair(5'd23, tw);
      end
    end else begin
      step(5'd7, C_NONE, 1'b0, "R7");
      if (op[0]) begin
        step(5'd14, C_AC2MBR, 1'b0, "R5");
        mem_loop(5'd15, C_WRITE, k, "R8");
        step(5'd17, C_NONE, 1'b0, "R9");
      end else begin
        mem_loop(5'd8, C_READ, k, "R8");
        step(5'd10, C_CAPT, 1'b0, "R5");
        step(5'd11, C_MBR2AC, 1'b0, "R9");
        ret_pair(5'd12, tw);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1 check(5'd0, C_FETCH, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int op = 0; op < 4; op++)
      for (int ac = 0; ac < 2; ac++)
        for (int k = 0; k < 4; k++)
          for (int tw = 0; tw < 2; tw++)
            run_instr(op[1:0], ac[0], k, tw[0]);
    step(5'd0, C_FETCH, 1'b0, "R6");
    step(5'd1, C_READ, 1'b1, "R6");
    rst_ni = 1'b0;
    #1 check(5'd0, C_FETCH, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(5'd0, C_FETCH, 1'b0, "R1");
    step(5'd1, C_READ, 1'b0, "R3");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule